// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's complement operands of a parameterised width `W` and returns the full `2W`-bit product. It works iteratively. A running partial sum, a shifting copy of the multiplier and one trailing bit below it are held in registers. In each clock cycle the lowest multiplier bit and the trailing bit are examined together. The multiplicand is then added, subtracted or skipped, and everything shifts right by one place with sign extension.

A request is made by pulsing `start_i` while the block is idle, with both operands present in that cycle. Loading takes one cycle and each of the `W` iterations takes one more. `done_o` then pulses for one cycle. The product stays on `product_o` until the next accepted request. Requests made while a multiplication is in progress are dropped.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` sampled high while idle captures both operands, and `busy_o` is high from the next cycle.
- R3: `busy_o` stays high for exactly `W` cycles. `done_o` rises in the cycle in which `busy_o` falls, which is the `W+1`-th cycle after the accepting edge.
- R4: `done_o` is high for exactly one cycle per multiplication.
- R5: `product_o` equals the signed product of multiplicand and multiplier, as a `2W`-bit two's complement value, for every combination of operand signs.
- R6: Operands equal to the most negative value (-2^(W-1)) give exact results. An example is (-2^(W-1))·(-2^(W-1)) = 2^(2W-2).
- R7: `start_i` is ignored while `busy_o` is high. It does not alter the result or the completion time of the multiplication in progress.
- R8: While idle and without an accepted start, `product_o` keeps its value regardless of the operand inputs.
- R9: Recoding uses the pair {lowest multiplier bit, trailing bit}. The pair 01 adds the multiplicand, 10 subtracts it, and 00 or 11 only shifts the partial sum arithmetically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, honoured only when idle |
| mcand_i | input | W | Multiplicand, two's complement |
| mplier_i | input | W | Multiplier, two's complement |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2W | Signed product {high half, low half} |

## Verification
The embedded properties are checked on every clock. They cover the following:
- the single-cycle done pulse;
- the alignment of done with the falling edge of busy;
- the counter continuing undisturbed when start arrives mid-operation;
- the multiplicand register staying frozen during a run;
- the product holding while idle;
- shift-only iterations sign-extending the partial sum.

Arithmetic correctness can only be shown by the bench scenarios. These include mixed-sign operands, most-negative corner operands, a start injected mid-run, and a hold period with operands toggling. They compare the product and the cycle count against a signed reference computed in the bench.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {OP_SHIFT = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2} booth_op_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} booth_st_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [1:0] pair_i,  // {q[0], q_m1}
  output booth_op_e  op_o
);
  always_comb begin
    unique case (pair_i)
      2'b01:   op_o = OP_ADD;
      2'b10:   op_o = OP_SUB;
      default: op_o = OP_SHIFT;
    endcase
  end
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           run_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  input  booth_op_e      op_i,
  output logic [1:0]     pair_o,
  output logic [2*W-1:0] product_o
);
  localparam int unsigned XW = W + 1;

  logic [W-1:0]  ac_q, q_q, mc_q;
  logic          qm1_q;
  logic [XW-1:0] ac_x, mc_x, sum;

  assign ac_x = {ac_q[W-1], ac_q};
  assign mc_x = {mc_q[W-1], mc_q};

  // extra bit keeps the true sign when subtracting the most negative value
  always_comb begin
    unique case (op_i)
      OP_ADD:  sum = ac_x + mc_x;
      OP_SUB:  sum = ac_x + (~mc_x) + XW'(1);
      default: sum = ac_x;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q  <= '0;
      q_q   <= '0;
      mc_q  <= '0;
      qm1_q <= 1'b0;
    end else if (load_i) begin
      ac_q  <= '0;
      q_q   <= mplier_i;
      mc_q  <= mcand_i;
      qm1_q <= 1'b0;
    end else if (run_i) begin
      ac_q  <= sum[XW-1:1];
      q_q   <= {sum[0], q_q[W-1:1]};
      qm1_q <= q_q[0];
    end
  end

  assign pair_o    = {q_q[0], qm1_q};
  assign product_o = {ac_q, q_q};

  // R9
  shift_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && op_i == OP_SHIFT) |=>
      ac_q == {$past(ac_q[W-1]), $past(ac_q[W-1:1])});

  // R7
  mcand_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> $stable(mc_q));

  // R8
  product_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(product_o));
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic run_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(W + 1);

  booth_st_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = start_i && (st_q == ST_IDLE);
  assign run_o  = (st_q == ST_RUN);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        st_q  <= ST_RUN;
        cnt_q <= CW'(W);
      end else if (run_o) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  done_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(run_o));

  // R7
  busy_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && start_i && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  logic      load, run;
  logic [1:0] pair;
  booth_op_e op;

  booth_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .run_o  (run),
    .done_o (done_o)
  );

  booth_recoder u_rec (
    .pair_i(pair),
    .op_o  (op)
  );

  booth_datapath #(.W(W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .run_i    (run),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .op_i     (op),
    .pair_o   (pair),
    .product_o(product_o)
  );

  assign busy_o = run;
endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mc = '0, mp = '0;
  logic           busy, done;
  logic [2*W-1:0] prod;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  booth_seq_mult #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(mc), .mplier_i(mp),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    int ai, bi;
    ai = int'($signed(a));
    bi = int'($signed(b));
    return (2*W)'(ai * bi);
  endfunction

  // start at a negedge; optionally re-pulse start one cycle later with junk operands
  task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit poke, input string req);
    int cyc;
    @(negedge clk);
    mc = a; mp = b; start = 1'b1;
    @(negedge clk);
    cyc = 1;
    if (poke) begin
      mc = ~a; mp = b + 8'd3;
    end else begin
      start = 1'b0;
    end
    chk("R2 busy after start", busy, 1);
    if (poke) begin
      @(negedge clk); cyc++;
      start = 1'b0;
      chk("R7 busy kept", busy, 1);
    end
    while (!done && cyc < W + 6) begin
      @(negedge clk); cyc++;
    end
    chk({req, " R3 latency"}, cyc, W + 1);
    chk({req, " R3 busy low at done"}, busy, 0);
    chk({req, " product"}, prod, ref_mul(a, b));
    @(negedge clk);
    chk("R4 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 product", prod, 0);
  endtask

  task automatic t_signs();
    do_mul(8'd7, 8'd3, 0, "R5 7*3");
    do_mul(8'd23, 8'hF7, 0, "R5 23*-9");
    do_mul(8'hF7, 8'd23, 0, "R5 -9*23");
    do_mul(8'hE5, 8'hC4, 0, "R5 -27*-60");
    do_mul(8'h00, 8'h5A, 0, "R5 0*90");
    do_mul(8'h55, 8'hAA, 0, "R9 alternating bits");
    do_mul(8'hFF, 8'hFF, 0, "R9 runs of ones");
  endtask

  task automatic t_extremes();
    do_mul(8'h80, 8'h80, 0, "R6 min*min");
    do_mul(8'h80, 8'h7F, 0, "R6 min*max");
    do_mul(8'h7F, 8'h80, 0, "R6 max*min");
    do_mul(8'h80, 8'hFF, 0, "R6 min*-1");
  endtask

  task automatic t_ignore();
    do_mul(8'd45, 8'hEC, 1, "R7 start while busy");
  endtask

  task automatic t_hold();
    logic [2*W-1:0] snap;
    do_mul(8'd19, 8'hD3, 0, "R8 setup");
    snap = prod;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      mc = 8'(i * 37); mp = 8'(i * 91 + 5);
    end
    chk("R8 product held", prod, snap);
    chk("R8 still idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signs();
    t_extremes();
    t_ignore();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule